// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block filters two independent MPEG transport streams by packet identifier (PID). Each stream owns a drop bitmap with one bit for each of the 8192 possible PIDs. A set bit discards every packet carrying that PID, and a clear bit lets the packet through. Packets enter one byte per cycle with a valid strobe and a start-of-packet flag. The block takes the 13-bit PID from the second and third bytes and then either forwards the whole packet or removes it from the output.

The host programs the bitmaps one byte at a time, eight PIDs per byte, through a small register window. Two address registers select the stream and the bitmap byte. A data register reads and writes the selected byte, so the host can flip a single PID with a read-modify-write. The first 32 PIDs always pass, whatever the bitmap holds. A packet that does not begin with the sync byte 0x47 is discarded.

Top module: `ts_pid_filter`

## Requirements
- R1: Register 0x8 holds the 8-bit low window address and register 0x9 holds the 3-bit high window address, which reads back in bits 2:0 with bits 7:3 zero. Bit 2 of the high address selects the stream (0 or 1) and bits 1:0 form bitmap index bits 9:8. Reads of addresses other than 0x8, 0x9 and 0xA return 0, and writes to them change nothing.
- R2: A write to data register 0xA stores the byte at the selected stream and index. A read of 0xA returns the stored byte.
- R3: The bitmap byte for a PID sits at index PID[12:3], and its bit PID[2:0] belongs to that PID. A 1 drops every packet with that PID and a 0 passes it.
- R4: Packets with PID 0x00 to 0x1F always pass, even when their bitmap bits are set.
- R5: A packet whose first byte is not 0x47 is dropped as a whole.
- R6: A packet is either forwarded with all its bytes, in order, with the start flag on its first output byte, or nothing of it is output.
- R7: Each stream is filtered only by its own bitmap. Writing one stream's bitmap has no effect on the other stream.
- R8: After reset every bitmap byte is 0, so all PIDs pass. The window registers read 0 and no output is valid.
- R9: Output byte k of a stream is registered on the clock edge that accepts input byte k+3 of that stream. Idle cycles on the input hold the output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, combinational from host_addr_i |
| ts_data_i | input | 16 | Input bytes, stream s in bits 8s+7:8s |
| ts_valid_i | input | 2 | Input byte valid, one bit per stream |
| ts_sop_i | input | 2 | Input first byte of a packet, one bit per stream |
| ts_data_o | output | 16 | Output bytes, stream s in bits 8s+7:8s |
| ts_valid_o | output | 2 | Output byte valid, one bit per stream |
| ts_sop_o | output | 2 | Output first byte of a packet, one bit per stream |

## Verification
Host reads are combinational. The bench checks them in the same cycle the address is applied, and a write is visible from the cycle after its strobe. Every input byte the bench drives gets a running index per stream. Each output byte seen after a clock edge must carry the index of the byte accepted three accepted-bytes earlier, so R9 latency is checked on every byte, including bytes that arrive with gaps. Forwarding decisions are predicted from a bench copy of the bitmap. That copy is updated only between packets, so the bitmap state each packet's decision uses is known exactly.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;
  localparam int NUM_STREAMS = 2;
  localparam int BYTE_W      = 8;
  localparam int PID_W       = 13;
  localparam int BIT_SEL_W   = 3;
  localparam int IDX_W       = PID_W - BIT_SEL_W;
  localparam int LOOKAHEAD   = 3;
  localparam int FREE_PIDS   = 32;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [3:0] REG_WIN_LO = 4'h8;
  localparam logic [3:0] REG_WIN_HI = 4'h9;
  localparam logic [3:0] REG_WIN_DATA = 4'hA;
endpackage

// File: rtl/pid_bitmap.sv
module pid_bitmap
  import ts_pid_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         host_idx_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic [BYTE_W-1:0]        host_byte_o,
  input  logic [IDX_W-1:0]         lk_idx_i,
  output logic [BYTE_W-1:0]        lk_byte_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[host_idx_i] <= wr_data_i;
    end
  end

  assign host_byte_o = mem_q[host_idx_i];
  assign lk_byte_o   = mem_q[lk_idx_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (host_idx_i != $past(host_idx_i)) || (host_byte_o == $past(wr_data_i)));
endmodule

// File: rtl/ts_stream_filter.sv
module ts_stream_filter
  import ts_pid_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic [BYTE_W-1:0] lk_byte_i,
  output logic              valid_o,
  output logic              sop_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CNT_W = $clog2(PKT_LEN + 1);
  localparam logic [CNT_W-1:0] PID_LO_POS = CNT_W'(2);

  logic [CNT_W-1:0]  cnt_q, pos;
  logic [BYTE_W-1:0] dl_data [LOOKAHEAD];
  logic              dl_sop  [LOOKAHEAD];
  logic              dl_vld  [LOOKAHEAD];
  logic              sync_ok_q, keep_q, pid_hit, drop_bit, keep_nxt;
  logic [PID_W-1:0]  pid;

  assign pos      = sop_i ? '0 : cnt_q;
  assign pid      = {dl_data[0][PID_W-BYTE_W-1:0], data_i};
  assign lk_idx_o = pid[PID_W-1:BIT_SEL_W];
  assign drop_bit = lk_byte_i[pid[BIT_SEL_W-1:0]];
  assign pid_hit  = valid_i && (pos == PID_LO_POS);
  assign keep_nxt = sync_ok_q && ((pid < PID_W'(FREE_PIDS)) || !drop_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sync_ok_q <= 1'b0;
      keep_q    <= 1'b0;
    end else if (valid_i) begin
      if (pos < CNT_W'(PKT_LEN)) cnt_q <= pos + 1'b1;
      if (pos == '0) sync_ok_q <= (data_i == SYNC_BYTE);
      if (pid_hit) keep_q <= keep_nxt;
    end
  end

  // byte delay line, shifts only on accepted bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_data[0] <= '0;
      dl_sop[0]  <= 1'b0;
      dl_vld[0]  <= 1'b0;
    end else if (valid_i) begin
      dl_data[0] <= data_i;
      dl_sop[0]  <= sop_i;
      dl_vld[0]  <= 1'b1;
    end
  end

  for (genvar g = 1; g < LOOKAHEAD; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dl_data[g] <= '0;
        dl_sop[g]  <= 1'b0;
        dl_vld[g]  <= 1'b0;
      end else if (valid_i) begin
        dl_data[g] <= dl_data[g-1];
        dl_sop[g]  <= dl_sop[g-1];
        dl_vld[g]  <= dl_vld[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i && dl_vld[LOOKAHEAD-1] && keep_q;
      sop_o   <= valid_i && dl_vld[LOOKAHEAD-1] && keep_q && dl_sop[LOOKAHEAD-1];
      if (valid_i) data_o <= dl_data[LOOKAHEAD-1];
    end
  end

  p_out_needs_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  p_sop_has_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> valid_o);
  p_free_pid_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pid_hit && sync_ok_q && (pid < PID_W'(FREE_PIDS))) |=> keep_q);
  p_bad_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (pos == '0) && (data_i != SYNC_BYTE)) |=> !sync_ok_q);
  p_keep_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pid_hit |=> $stable(keep_q));
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pid_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            host_wr_i,
  input  logic [3:0]                      host_addr_i,
  input  logic [7:0]                      host_wdata_i,
  output logic [7:0]                      host_rdata_o,
  input  logic [NUM_STREAMS*BYTE_W-1:0]   ts_data_i,
  input  logic [NUM_STREAMS-1:0]          ts_valid_i,
  input  logic [NUM_STREAMS-1:0]          ts_sop_i,
  output logic [NUM_STREAMS*BYTE_W-1:0]   ts_data_o,
  output logic [NUM_STREAMS-1:0]          ts_valid_o,
  output logic [NUM_STREAMS-1:0]          ts_sop_o
);
  localparam int HI_W = IDX_W - 8 + 1;

  logic [7:0]        win_lo_q;
  logic [HI_W-1:0]   win_hi_q;
  logic [IDX_W-1:0]  win_idx;
  logic              win_sel;
  logic [BYTE_W-1:0] host_byte [NUM_STREAMS];

  assign win_idx = {win_hi_q[HI_W-2:0], win_lo_q};
  assign win_sel = win_hi_q[HI_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_lo_q <= '0;
      win_hi_q <= '0;
    end else if (host_wr_i) begin
      if (host_addr_i == REG_WIN_LO) win_lo_q <= host_wdata_i;
      if (host_addr_i == REG_WIN_HI) win_hi_q <= host_wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    case (host_addr_i)
      REG_WIN_LO:   host_rdata_o = win_lo_q;
      REG_WIN_HI:   host_rdata_o = 8'(win_hi_q);
      REG_WIN_DATA: host_rdata_o = host_byte[win_sel];
      default:      host_rdata_o = '0;
    endcase
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic [IDX_W-1:0]  lk_idx;
    logic [BYTE_W-1:0] lk_byte;
    logic              wr_en;

    assign wr_en = host_wr_i && (host_addr_i == REG_WIN_DATA) && (win_sel == 1'(s));

    pid_bitmap u_bitmap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en),
      .host_idx_i  (win_idx),
      .wr_data_i   (host_wdata_i),
      .host_byte_o (host_byte[s]),
      .lk_idx_i    (lk_idx),
      .lk_byte_o   (lk_byte)
    );

    ts_stream_filter #(.PKT_LEN(PKT_LEN)) u_filter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (ts_valid_i[s]),
      .sop_i     (ts_sop_i[s]),
      .data_i    (ts_data_i[s*BYTE_W +: BYTE_W]),
      .lk_idx_o  (lk_idx),
      .lk_byte_i (lk_byte),
      .valid_o   (ts_valid_o[s]),
      .sop_o     (ts_sop_o[s]),
      .data_o    (ts_data_o[s*BYTE_W +: BYTE_W])
    );
  end

  p_data_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == REG_WIN_DATA) |=>
      (host_addr_i != REG_WIN_DATA) || (host_rdata_o == $past(host_wdata_i)));
  p_lo_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == REG_WIN_LO) |=>
      (host_addr_i != REG_WIN_LO) || (host_rdata_o == $past(host_wdata_i)));
  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i < REG_WIN_LO || host_addr_i > REG_WIN_DATA) |-> host_rdata_o == 8'h00);
endmodule

// File: tb/ts_pid_filter_tb.sv
module ts_pid_filter_tb;
  import ts_pid_pkg::*;
  localparam int NS = NUM_STREAMS;
  localparam int PL = 188;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [15:0] ts_data_i = '0;
  logic [1:0]  ts_valid_i = '0, ts_sop_i = '0;
  logic [15:0] ts_data_o;
  logic [1:0]  ts_valid_o, ts_sop_o;

  int checks = 0, fails = 0;
  bit bm [NS][8192];
  int q0[$], q1[$];
  int acc [NS];
  bit sample_en = 1'b0;

  ts_pid_filter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .ts_data_i(ts_data_i), .ts_valid_i(ts_valid_i), .ts_sop_i(ts_sop_i),
    .ts_data_o(ts_data_o), .ts_valid_o(ts_valid_o), .ts_sop_o(ts_sop_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic sample_outputs();
    for (int s = 0; s < NS; s++) begin
      if (ts_valid_o[s]) begin
        int e;
        int sz;
        sz = (s == 0) ? q0.size() : q1.size();
        if (sz == 0) begin
          chk(0, "R6 unexpected output byte", ts_data_o[s*8 +: 8], 0);
        end else begin
          e = (s == 0) ? q0.pop_front() : q1.pop_front();
          chk(ts_data_o[s*8 +: 8] == e[7:0], "R6 R3 output data", ts_data_o[s*8 +: 8], e[7:0]);
          chk(ts_sop_o[s] == e[8], "R6 sop flag", ts_sop_o[s], e[8]);
          chk(acc[s] == (e >> 9) + 4, "R9 latency", acc[s], (e >> 9) + 4);
        end
      end else if (ts_sop_o[s]) begin
        chk(0, "R6 sop without valid", 1, 0);
      end
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [15:0] d, input logic [1:0] sp);
    @(negedge clk);
    if (sample_en) sample_outputs();
    host_wr = 1'b0;
    ts_valid_i = v;
    ts_data_i = d;
    ts_sop_i = sp & v;
    for (int s = 0; s < NS; s++) if (v[s]) acc[s]++;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] dat);
    @(negedge clk);
    if (sample_en) sample_outputs();
    ts_valid_i = '0;
    host_wr = 1'b1;
    host_addr = a;
    host_wdata = dat;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] dat);
    @(negedge clk);
    if (sample_en) sample_outputs();
    ts_valid_i = '0;
    host_wr = 1'b0;
    host_addr = a;
    #1 dat = host_rdata;
  endtask

  task automatic set_byte(input int s, input int idx, input logic [7:0] val);
    host_write(REG_WIN_LO, 8'(idx));
    host_write(REG_WIN_HI, {5'b0, 1'(s), 2'(idx >> 8)});
    host_write(REG_WIN_DATA, val);
    for (int b = 0; b < 8; b++) bm[s][idx*8 + b] = val[b];
  endtask

  task automatic rmw_pid(input int s, input int pid, input bit val);
    logic [7:0] b;
    logic [7:0] m;
    int idx;
    idx = pid >> 3;
    host_write(REG_WIN_LO, 8'(idx));
    host_write(REG_WIN_HI, {5'b0, 1'(s), 2'(idx >> 8)});
    host_read(REG_WIN_DATA, b);
    for (int k = 0; k < 8; k++) m[k] = bm[s][idx*8 + k];
    chk(b == m, "R2 data readback", b, m);
    b[pid & 7] = val;
    host_write(REG_WIN_DATA, b);
    bm[s][pid] = val;
  endtask

  function automatic bit passes(input int s, input int pid, input logic [7:0] sync);
    return (sync == SYNC_BYTE) && ((pid < FREE_PIDS) || !bm[s][pid]);
  endfunction

  task automatic send_pair(input int pid0, input logic [7:0] sy0, input int pid1, input logic [7:0] sy1);
    logic [7:0] pk [NS][PL];
    bit ps [NS];
    int ptr [NS];
    int pids [NS];
    logic [7:0] sys [NS];
    pids[0] = pid0; pids[1] = pid1; sys[0] = sy0; sys[1] = sy1;
    for (int s = 0; s < NS; s++) begin
      pk[s][0] = sys[s];
      pk[s][1] = {3'($urandom), 5'(pids[s] >> 8)};
      pk[s][2] = 8'(pids[s]);
      for (int i = 3; i < PL; i++) pk[s][i] = 8'($urandom);
      ps[s] = passes(s, pids[s], sys[s]);
      ptr[s] = 0;
    end
    while (ptr[0] < PL || ptr[1] < PL) begin
      logic [1:0] v, sp;
      logic [15:0] d;
      v = '0; sp = '0; d = '0;
      for (int s = 0; s < NS; s++) begin
        if (ptr[s] < PL && ($urandom % 4) != 0) begin
          v[s] = 1'b1;
          d[s*8 +: 8] = pk[s][ptr[s]];
          sp[s] = (ptr[s] == 0);
          if (ps[s]) begin
            int e;
            e = (acc[s] << 9) | (int'(sp[s]) << 8) | int'(pk[s][ptr[s]]);
            if (s == 0) q0.push_back(e); else q1.push_back(e);
          end
          ptr[s]++;
        end
      end
      step(v, d, sp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int pool [16];
    void'($urandom(32'd2718));
    for (int s = 0; s < NS; s++) acc[s] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ts_valid_o == 2'b00, "R8 no output in reset", ts_valid_o, 0);
    rst_ni = 1'b1;
    sample_en = 1'b1;

    // R8 reset state, R1 window registers
    host_read(REG_WIN_LO, r);   chk(r == 8'h00, "R8 low window reset", r, 0);
    host_read(REG_WIN_HI, r);   chk(r == 8'h00, "R8 high window reset", r, 0);
    host_read(REG_WIN_DATA, r); chk(r == 8'h00, "R8 bitmap reset", r, 0);
    host_write(REG_WIN_HI, 8'hFF);
    host_write(REG_WIN_LO, 8'hFF);
    host_read(REG_WIN_HI, r);   chk(r == 8'h07, "R1 high window bits", r, 8'h07);
    host_read(REG_WIN_DATA, r); chk(r == 8'h00, "R8 bitmap top byte reset", r, 0);
    host_write(4'h5, 8'hAA);
    host_read(REG_WIN_LO, r);   chk(r == 8'hFF, "R1 unmapped write ignored", r, 8'hFF);
    host_read(4'h5, r);         chk(r == 8'h00, "R1 unmapped read zero", r, 0);
    host_read(4'h3, r);         chk(r == 8'h00, "R1 unmapped read zero", r, 0);

    // R7 stream select and independence
    set_byte(1, 300, 8'h5A);
    set_byte(0, 300, 8'hC3);
    host_write(REG_WIN_HI, 8'h05);
    host_read(REG_WIN_DATA, r); chk(r == 8'h5A, "R7 stream 1 byte kept", r, 8'h5A);
    host_write(REG_WIN_HI, 8'h01);
    host_read(REG_WIN_DATA, r); chk(r == 8'hC3, "R2 stream 0 byte", r, 8'hC3);
    set_byte(0, 300, 8'h00);
    set_byte(1, 300, 8'h00);

    // main path
    send_pair(13'h100, SYNC_BYTE, 13'h100, SYNC_BYTE);
    rmw_pid(0, 13'h100, 1'b1);
    send_pair(13'h100, SYNC_BYTE, 13'h100, SYNC_BYTE);   // R3 drop on 0, R7 pass on 1
    set_byte(0, 3, 8'hFF);
    set_byte(1, 0, 8'hFF);
    send_pair(13'h1F, SYNC_BYTE, 13'h05, SYNC_BYTE);     // R4 free PIDs
    rmw_pid(0, 13'h20, 1'b1);
    send_pair(13'h20, SYNC_BYTE, 13'h20, SYNC_BYTE);     // R3 first filtered PID
    send_pair(13'h200, 8'h46, 13'h200, SYNC_BYTE);       // R5 bad sync
    rmw_pid(1, 13'h1FFF, 1'b1);
    send_pair(13'h1FFF, SYNC_BYTE, 13'h1FFF, SYNC_BYTE); // R3 top PID
    rmw_pid(0, 13'h100, 1'b0);
    send_pair(13'h100, SYNC_BYTE, 13'h100, SYNC_BYTE);

    // random mix
    for (int i = 0; i < 16; i++) pool[i] = (i < 2) ? i * 17 : int'($urandom % 8192);
    for (int it = 0; it < 30; it++) begin
      rmw_pid(int'($urandom % 2), pool[$urandom % 16], 1'($urandom));
      send_pair(pool[$urandom % 16], ($urandom % 8 == 0) ? 8'h00 : SYNC_BYTE,
                pool[$urandom % 16], ($urandom % 8 == 0) ? 8'hB8 : SYNC_BYTE);
    end

    // trailing packet: last three bytes stay in the lookahead line
    send_pair(0, SYNC_BYTE, 0, SYNC_BYTE);
    repeat (10) step(2'b00, 16'h0, 2'b00);
    chk(q0.size() == 3, "R6 R9 stream 0 tail held", q0.size(), 3);
    chk(q1.size() == 3, "R6 R9 stream 1 tail held", q1.size(), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule